// File: doc/BRIEF.md
# Accumulator Control Sequencer

This block is a compact programmable controller. It reads 18-bit instruction words from an external program ROM and runs them one after another against a 32-bit accumulator. Each word holds an opcode, a condition selector and a 10-bit operand. Instructions can:

- build constants in the accumulator a byte at a time;
- move the accumulator to or from the outside world through a single request channel;
- redirect the program counter with conditional jumps, calls and returns.

Returns use a small internal return-address stack.

Every data movement goes through one valid/ready request channel. A 2-bit target field selects the destination: register file, I/O port, ALU operand port or memory port. A direction bit says whether the accumulator is written out or loaded. The block raises `xfer_valid` and then holds target, direction, index and write data steady until it samples `xfer_ready` high on a rising edge. That edge completes the transfer, and on reads the block captures `xfer_rdata` there. The far side may hold `xfer_ready` low for any number of cycles. While a transfer is waiting the sequencer does nothing else. `xfer_ready` has no effect while `xfer_valid` is low.

Condition selection uses a 4-bit comparison flag input (equal, less, greater, unordered) from the external ALU, together with a zero test on the accumulator. The ROM must return the word for `rom_addr` one clock after the address is presented.

Top module: `acc_sequencer`

## Requirements
- R1: The instruction word fields are:
  - opcode in bits 17..14;
  - condition in bits 13..10;
  - operand in bits 9..0, with the byte value in bits 7..0 and the transfer index in bits 7..0.
  
  After reset `rom_addr` is 0. Each instruction is fetched over two cycles, and `rom_addr` stays unchanged between the fetch cycle and the execute cycle.
- R2: Opcode 0 loads the byte value into accumulator bits 7..0 and clears bits 31..8.
- R3: Opcode 1 shifts the accumulator right by 8 and places the byte value in bits 31..24.
- R4: Transfer opcodes map to target and direction as follows (`xfer_target`, `xfer_we`):
  - 2: register read (0, 0); 3: register write (0, 1);
  - 4: I/O input (1, 0); 5: I/O output (1, 1);
  - 6: ALU send (2, 1); 7: ALU read (2, 0);
  - 11: memory load (3, 0); 12: memory store (3, 1).
  
  Writes present the accumulator on `xfer_wdata`. Reads load `xfer_rdata` into the accumulator at the completing edge.
- R5: Once `xfer_valid` is high, it stays high with target, direction, index and write data unchanged until a cycle in which `xfer_ready` is high. After that the program counter advances by one.
- R6: Condition codes are evaluated from `cmp_flags` (bit0 equal, bit1 less, bit2 greater, bit3 unordered) and the accumulator:
  - 0x1: equal; 0x2: less; 0x4: greater; 0x8: unordered;
  - 0x3: equal or less; 0x5: equal or greater; 0x6: not equal;
  - 0xB: accumulator zero; 0xC: accumulator non-zero; 0xF: always.
  
  Every other code is false.
- R7: Opcode 8 with a true condition passes through a branch state and loads the operand into the program counter. With a false condition the program counter increments.
- R8: Opcode 9 with a true condition pushes the address after the call onto a 4-entry return stack and jumps to the operand. With a false condition it pushes nothing and advances.
- R9: Opcode 10 with a true condition and a non-empty stack pops the top entry into the program counter.
- R10: A push to a full stack or a pop from an empty stack sets `stack_err`. The flag stays set until reset, and the stack pointer saturates. An overflowing call still jumps but stores nothing. An underflowing return advances by one.
- R11: Opcodes 13 to 15 leave the accumulator unchanged and advance the program counter by one.
- R12: A synchronous reset returns to fetching address 0, clears the accumulator, the stack and `stack_err`, and drops `xfer_valid`, including in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | 10 | Program counter presented to the ROM |
| rom_data | input | 18 | Instruction word, valid one cycle after the address |
| cmp_flags | input | 4 | ALU compare flags: equal, less, greater, unordered |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Far side accepts or completes the transfer |
| xfer_target | output | 2 | 0 register file, 1 I/O, 2 ALU, 3 memory |
| xfer_we | output | 1 | 1 write accumulator out, 0 load into accumulator |
| xfer_idx | output | 8 | Register, port or memory index |
| xfer_wdata | output | 32 | Accumulator value for writes |
| xfer_rdata | input | 32 | Data returned for reads |
| stack_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
On every cycle, the checker watches the transfer channel holding still under back-pressure, the ROM address holding across fetch and execute, and the two accumulator byte loads. It also checks that the stack-error flag is sticky and the stack pointer stays in range, and it covers the state that reset leaves. The decoding of every condition code against flag patterns, the transfer opcode mapping, and nested calls that overflow and then return from saturated entries can only be shown by the bench's programs. The same holds for untaken calls followed by underflowing returns, undefined opcodes, and reset during a stalled transfer.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OP_W = 4;
  localparam int CC_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SETB    = 4'd0,
    OP_SHIN    = 4'd1,
    OP_RF_RD   = 4'd2,
    OP_RF_WR   = 4'd3,
    OP_IO_IN   = 4'd4,
    OP_IO_OUT  = 4'd5,
    OP_ALU_PUT = 4'd6,
    OP_ALU_GET = 4'd7,
    OP_JMP     = 4'd8,
    OP_CALL    = 4'd9,
    OP_RET     = 4'd10,
    OP_MEM_RD  = 4'd11,
    OP_MEM_WR  = 4'd12
  } op_e;

  typedef enum logic [CC_W-1:0] {
    CC_EQ  = 4'h1,
    CC_LT  = 4'h2,
    CC_LE  = 4'h3,
    CC_GT  = 4'h4,
    CC_GE  = 4'h5,
    CC_NE  = 4'h6,
    CC_UN  = 4'h8,
    CC_AZ  = 4'hB,
    CC_ANZ = 4'hC,
    CC_ALW = 4'hF
  } cc_e;

  typedef enum logic [1:0] {
    TGT_REG = 2'd0,
    TGT_IO  = 2'd1,
    TGT_ALU = 2'd2,
    TGT_MEM = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    S_FETCH  = 2'd0,
    S_EXEC   = 2'd1,
    S_WAIT   = 2'd2,
    S_BRANCH = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic ld_const;
    logic ld_shift;
    logic xfer;
    tgt_e tgt;
    logic wr;
    logic jmp;
    logic call;
    logic ret;
  } dec_t;

  // compare flag bit positions
  localparam int FL_EQ = 0;
  localparam int FL_LT = 1;
  localparam int FL_GT = 2;
  localparam int FL_UN = 3;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IMM_W  = 8,
  parameter int IDX_W  = 8,
  localparam int INSTR_W = OP_W + CC_W + ADDR_W
) (
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec,
  output logic [IMM_W-1:0]   imm,
  output logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  target,
  output logic [CC_W-1:0]    cc
);

  logic [OP_W-1:0] op;

  assign op     = instr[ADDR_W+CC_W +: OP_W];
  assign cc     = instr[ADDR_W +: CC_W];
  assign target = instr[ADDR_W-1:0];
  assign imm    = instr[IMM_W-1:0];
  assign idx    = instr[IDX_W-1:0];

  always_comb begin
    dec = '0;
    case (op)
      OP_SETB:    dec.ld_const = 1'b1;
      OP_SHIN:    dec.ld_shift = 1'b1;
      OP_RF_RD:   begin dec.xfer = 1'b1; dec.tgt = TGT_REG; dec.wr = 1'b0; end
      OP_RF_WR:   begin dec.xfer = 1'b1; dec.tgt = TGT_REG; dec.wr = 1'b1; end
      OP_IO_IN:   begin dec.xfer = 1'b1; dec.tgt = TGT_IO;  dec.wr = 1'b0; end
      OP_IO_OUT:  begin dec.xfer = 1'b1; dec.tgt = TGT_IO;  dec.wr = 1'b1; end
      OP_ALU_PUT: begin dec.xfer = 1'b1; dec.tgt = TGT_ALU; dec.wr = 1'b1; end
      OP_ALU_GET: begin dec.xfer = 1'b1; dec.tgt = TGT_ALU; dec.wr = 1'b0; end
      OP_MEM_RD:  begin dec.xfer = 1'b1; dec.tgt = TGT_MEM; dec.wr = 1'b0; end
      OP_MEM_WR:  begin dec.xfer = 1'b1; dec.tgt = TGT_MEM; dec.wr = 1'b1; end
      OP_JMP:     dec.jmp  = 1'b1;
      OP_CALL:    dec.call = 1'b1;
      OP_RET:     dec.ret  = 1'b1;
      default:    dec = '0;
    endcase
  end

endmodule

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
  import acc_seq_pkg::*;
(
  input  logic [CC_W-1:0] cc,
  input  logic [3:0]      flags,
  input  logic            acc_zero,
  output logic            taken
);

  logic f_eq, f_lt, f_gt, f_un;

  assign f_eq = flags[FL_EQ];
  assign f_lt = flags[FL_LT];
  assign f_gt = flags[FL_GT];
  assign f_un = flags[FL_UN];

  always_comb begin
    case (cc)
      CC_EQ:   taken = f_eq;
      CC_LT:   taken = f_lt;
      CC_LE:   taken = f_eq | f_lt;
      CC_GT:   taken = f_gt;
      CC_GE:   taken = f_eq | f_gt;
      CC_NE:   taken = ~f_eq;
      CC_UN:   taken = f_un;
      CC_AZ:   taken = acc_zero;
      CC_ANZ:  taken = ~acc_zero;
      CC_ALW:  taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top,
  output logic              nonempty,
  output logic              err,
  output logic [SP_W-1:0]   sp
);

  logic [ADDR_W-1:0] ent [DEPTH];
  logic              full;
  logic [PTR_W-1:0]  top_ptr;

  assign full     = (sp == SP_W'(DEPTH));
  assign nonempty = (sp != '0);
  assign top_ptr  = PTR_W'(sp - 1'b1);
  assign top      = ent[top_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (push && !full && sp == SP_W'(g))
        ent[g] <= push_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp  <= '0;
      err <= 1'b0;
    end else if (push) begin
      if (full) err <= 1'b1;
      else      sp  <= sp + 1'b1;
    end else if (pop) begin
      if (!nonempty) err <= 1'b1;
      else           sp  <= sp - 1'b1;
    end
  end

endmodule

// File: rtl/acc_sequencer.sv
module acc_sequencer
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int IMM_W       = 8,
  parameter int IDX_W       = 8,
  parameter int STACK_DEPTH = 4,
  localparam int INSTR_W    = OP_W + CC_W + ADDR_W,
  localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  rom_addr,
  input  logic [INSTR_W-1:0] rom_data,
  input  logic [3:0]         cmp_flags,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [1:0]         xfer_target,
  output logic               xfer_we,
  output logic [IDX_W-1:0]   xfer_idx,
  output logic [DATA_W-1:0]  xfer_wdata,
  input  logic [DATA_W-1:0]  xfer_rdata,
  output logic               stack_err
);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc, pc_inc, ret_addr;
  logic [DATA_W-1:0] acc;

  dec_t              dec;
  logic [IMM_W-1:0]  imm;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] jtgt;
  logic [CC_W-1:0]   cc;
  logic              taken, do_push, do_pop, stk_has;
  logic [SP_W-1:0]   sp;

  tgt_e              xt_q;
  logic              xw_q;
  logic [IDX_W-1:0]  xi_q;

  seq_decode #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .instr (rom_data),
    .dec   (dec),
    .imm   (imm),
    .idx   (idx),
    .target(jtgt),
    .cc    (cc)
  );

  seq_cond_eval u_cond (
    .cc      (cc),
    .flags   (cmp_flags),
    .acc_zero(acc == '0),
    .taken   (taken)
  );

  assign pc_inc  = pc + 1'b1;
  assign do_push = (state == S_EXEC) && dec.call && taken;
  assign do_pop  = (state == S_EXEC) && dec.ret && taken;

  seq_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (do_push),
    .pop      (do_pop),
    .push_addr(pc_inc),
    .top      (ret_addr),
    .nonempty (stk_has),
    .err      (stack_err),
    .sp       (sp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_FETCH;
      pc         <= '0;
      acc        <= '0;
      xfer_valid <= 1'b0;
      xt_q       <= TGT_REG;
      xw_q       <= 1'b0;
      xi_q       <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_EXEC;

        S_EXEC: begin
          if (dec.ld_const) begin
            acc   <= {{(DATA_W-IMM_W){1'b0}}, imm};
            pc    <= pc_inc;
            state <= S_FETCH;
          end else if (dec.ld_shift) begin
            acc   <= {imm, acc[DATA_W-1:IMM_W]};
            pc    <= pc_inc;
            state <= S_FETCH;
          end else if (dec.xfer) begin
            xt_q       <= dec.tgt;
            xw_q       <= dec.wr;
            xi_q       <= idx;
            xfer_valid <= 1'b1;
            state      <= S_WAIT;
          end else if ((dec.jmp || dec.call) && taken) begin
            pc    <= jtgt;
            state <= S_BRANCH;
          end else if (dec.ret && taken && stk_has) begin
            pc    <= ret_addr;
            state <= S_BRANCH;
          end else begin
            pc    <= pc_inc;
            state <= S_FETCH;
          end
        end

        S_WAIT: begin
          if (xfer_ready) begin
            xfer_valid <= 1'b0;
            if (!xw_q) acc <= xfer_rdata;
            pc    <= pc_inc;
            state <= S_FETCH;
          end
        end

        S_BRANCH: state <= S_FETCH;

        default: state <= S_FETCH;
      endcase
    end
  end

  assign rom_addr    = pc;
  assign xfer_target = xt_q;
  assign xfer_we     = xw_q;
  assign xfer_idx    = xi_q;
  assign xfer_wdata  = acc;

endmodule

// File: rtl/acc_sequencer_chk.sv
module acc_sequencer_chk
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int IMM_W       = 8,
  parameter int IDX_W       = 8,
  parameter int STACK_DEPTH = 4,
  localparam int INSTR_W    = OP_W + CC_W + ADDR_W,
  localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  rom_addr,
  input logic [INSTR_W-1:0] rom_data,
  input logic               xfer_valid,
  input logic               xfer_ready,
  input logic [1:0]         xfer_target,
  input logic               xfer_we,
  input logic [IDX_W-1:0]   xfer_idx,
  input logic [DATA_W-1:0]  xfer_wdata,
  input logic               stack_err,
  input seq_state_e         state,
  input logic [DATA_W-1:0]  acc,
  input logic [SP_W-1:0]    sp
);

  logic [OP_W-1:0] op_f;
  assign op_f = rom_data[ADDR_W+CC_W +: OP_W];

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC) |-> (rom_addr == $past(rom_addr)));

  assert_const_load_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op_f == OP_SETB) |=>
      (acc == {{(DATA_W-IMM_W){1'b0}}, $past(rom_data[IMM_W-1:0])}));

  assert_shift_load_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op_f == OP_SHIN) |=>
      (acc == {$past(rom_data[IMM_W-1:0]), $past(acc[DATA_W-1:IMM_W])}));

  assert_xfer_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_target) && $stable(xfer_we) &&
       $stable(xfer_idx) && $stable(xfer_wdata)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);

  assert_sp_bound_R10: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_W'(STACK_DEPTH));

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (!xfer_valid && rom_addr == '0 && !stack_err && state == S_FETCH));

endmodule

bind acc_sequencer acc_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W),
  .STACK_DEPTH(STACK_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_target(xfer_target),
  .xfer_we(xfer_we), .xfer_idx(xfer_idx), .xfer_wdata(xfer_wdata),
  .stack_err(stack_err), .state(state), .acc(acc), .sp(sp)
);

// File: tb/tb_acc_sequencer.sv
module tb_acc_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  rom_addr;
  logic [17:0] rom_data;
  logic [3:0]  cmp_flags = 4'h0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [1:0]  xfer_target;
  logic        xfer_we;
  logic [7:0]  xfer_idx;
  logic [31:0] xfer_wdata;
  logic [31:0] xfer_rdata = 32'h0;
  logic        stack_err;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  logic [17:0] rom [1024];

  always #5 clk = ~clk;

  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  acc_sequencer dut (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .cmp_flags(cmp_flags), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_target(xfer_target), .xfer_we(xfer_we), .xfer_idx(xfer_idx),
    .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata), .stack_err(stack_err)
  );

  // condition table: {cond[3:0], flags[3:0], acc_nonzero, expect_taken}
  localparam logic [9:0] CTAB [18] = '{
    {4'h1, 4'b0001, 1'b0, 1'b1},
    {4'h1, 4'b0010, 1'b0, 1'b0},
    {4'h2, 4'b0010, 1'b0, 1'b1},
    {4'h3, 4'b0001, 1'b0, 1'b1},
    {4'h3, 4'b0100, 1'b0, 1'b0},
    {4'h4, 4'b0100, 1'b0, 1'b1},
    {4'h5, 4'b0010, 1'b0, 1'b0},
    {4'h5, 4'b0001, 1'b0, 1'b1},
    {4'h6, 4'b0001, 1'b0, 1'b0},
    {4'h6, 4'b0100, 1'b0, 1'b1},
    {4'h8, 4'b1000, 1'b0, 1'b1},
    {4'h6, 4'b1000, 1'b0, 1'b1},
    {4'hB, 4'b0000, 1'b0, 1'b1},
    {4'hB, 4'b0000, 1'b1, 1'b0},
    {4'hC, 4'b0000, 1'b1, 1'b1},
    {4'hF, 4'b0000, 1'b0, 1'b1},
    {4'h0, 4'b1111, 1'b0, 1'b0},
    {4'h7, 4'b1111, 1'b1, 1'b0}
  };

  localparam logic [3:0] XOPS [8] = '{4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd11, 4'd12};

  function automatic logic [17:0] mkw(input logic [3:0] op, input logic [3:0] cc,
                                      input logic [9:0] opnd);
    return {op, cc, opnd};
  endfunction

  function automatic logic [2:0] exp_tw(input logic [3:0] op);
    case (op)
      4'd2:  return {2'd0, 1'b0};
      4'd3:  return {2'd0, 1'b1};
      4'd4:  return {2'd1, 1'b0};
      4'd5:  return {2'd1, 1'b1};
      4'd6:  return {2'd2, 1'b1};
      4'd7:  return {2'd2, 1'b0};
      4'd11: return {2'd3, 1'b0};
      default: return {2'd3, 1'b1};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int a = 0; a < 1024; a++) rom[a] = mkw(4'd8, 4'hF, 10'(a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits for a request, holds ready low for dly cycles, then completes it
  task automatic serve(input int dly, input logic [31:0] rd, output bit got,
                       output logic [1:0] tg, output logic w,
                       output logic [7:0] ix, output logic [31:0] wd);
    got = 1'b0;
    for (int k = 0; k < 60 && !got; k++) begin
      if (xfer_valid) got = 1'b1;
      else @(negedge clk);
    end
    tg = xfer_target; w = xfer_we; ix = xfer_idx; wd = xfer_wdata;
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R5 valid held", {31'b0, xfer_valid}, 32'd1);
      chk("R5 fields held", {21'b0, xfer_target, xfer_we, xfer_idx, 32'(xfer_wdata == wd) == 1 ? 1'b1 : 1'b0},
          {21'b0, tg, w, ix, 1'b1});
    end
    xfer_rdata = rd;
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    bit got;
    logic [1:0] tg;
    logic w;
    logic [7:0] ix;
    logic [31:0] wd;

    clear_rom();
    do_reset();
    @(negedge clk);
    // R12 / R1: reset state
    chk("R12 rom_addr after reset", {22'b0, rom_addr}, 32'd0);
    chk("R12 xfer_valid after reset", {31'b0, xfer_valid}, 32'd0);
    chk("R12 stack_err after reset", {31'b0, stack_err}, 32'd0);

    // R6 / R7: condition table walk
    for (int i = 0; i < 18; i++) begin
      clear_rom();
      rom[0] = mkw(4'd0, 4'h0, {9'b0, CTAB[i][1]});
      rom[1] = mkw(4'd8, CTAB[i][9:6], 10'h020);
      cmp_flags = CTAB[i][5:2];
      do_reset();
      run(20);
      chk($sformatf("R6 R7 cond %h flags %b", CTAB[i][9:6], CTAB[i][5:2]),
          {22'b0, rom_addr}, CTAB[i][0] ? 32'h20 : 32'h2);
    end
    cmp_flags = 4'h0;

    // R4: transfer opcode mapping and data movement
    for (int i = 0; i < 8; i++) begin
      logic [2:0] e;
      e = exp_tw(XOPS[i]);
      clear_rom();
      rom[0] = mkw(4'd0, 4'h0, 10'h03C);
      rom[1] = mkw(XOPS[i], 4'h0, 10'(8'h40 + i));
      if (!e[0]) rom[2] = mkw(4'd5, 4'h0, 10'h000);
      do_reset();
      serve(i % 3, 32'hA500_0000 | 32'(i), got, tg, w, ix, wd);
      chk($sformatf("R4 op %0d request seen", XOPS[i]), {31'b0, got}, 32'd1);
      chk($sformatf("R4 op %0d target/we", XOPS[i]), {29'b0, tg, w}, {29'b0, e});
      chk($sformatf("R4 op %0d index", XOPS[i]), {24'b0, ix}, 32'(8'h40 + i));
      if (e[0]) begin
        chk($sformatf("R4 op %0d wdata", XOPS[i]), wd, 32'h3C);
        run(10);
        chk("R5 pc advances after handshake", {22'b0, rom_addr}, 32'd2);
      end else begin
        serve(0, 32'h0, got, tg, w, ix, wd);
        chk($sformatf("R4 op %0d read loads acc", XOPS[i]), wd, 32'hA500_0000 | 32'(i));
        run(10);
        chk("R5 pc advances after handshake", {22'b0, rom_addr}, 32'd3);
      end
    end

    // R2 / R3 / R11: constant building, clearing, undefined opcodes
    clear_rom();
    rom[0]  = mkw(4'd0, 4'h0, 10'h055);
    rom[1]  = mkw(4'd1, 4'h0, 10'h0AA);
    rom[2]  = mkw(4'd1, 4'h0, 10'h0BB);
    rom[3]  = mkw(4'd1, 4'h0, 10'h0CC);
    rom[4]  = mkw(4'd1, 4'h0, 10'h0DD);
    rom[5]  = mkw(4'd5, 4'h0, 10'h001);
    rom[6]  = mkw(4'd1, 4'h0, 10'h0FF);
    rom[7]  = mkw(4'd1, 4'h0, 10'h0FF);
    rom[8]  = mkw(4'd1, 4'h0, 10'h0FF);
    rom[9]  = mkw(4'd1, 4'h0, 10'h0FF);
    rom[10] = mkw(4'd0, 4'h0, 10'h012);
    rom[11] = mkw(4'd5, 4'h0, 10'h002);
    rom[12] = mkw(4'd13, 4'hF, 10'h3FF);
    rom[13] = mkw(4'd15, 4'hF, 10'h123);
    rom[14] = mkw(4'd14, 4'h0, 10'h0AB);
    rom[15] = mkw(4'd5, 4'h0, 10'h003);
    do_reset();
    serve(0, 32'h0, got, tg, w, ix, wd);
    chk("R3 shifted bytes build constant", wd, 32'hDDCC_BBAA);
    serve(0, 32'h0, got, tg, w, ix, wd);
    chk("R2 byte load clears upper bits", wd, 32'h0000_0012);
    serve(0, 32'h0, got, tg, w, ix, wd);
    chk("R11 undefined opcodes keep acc", wd, 32'h0000_0012);
    chk("R11 undefined opcodes reach next word", {24'b0, ix}, 32'h03);
    run(10);
    chk("R11 program halts at 16", {22'b0, rom_addr}, 32'd16);

    // R8 / R9: call and return
    clear_rom();
    rom[0]    = mkw(4'd9, 4'hF, 10'h040);
    rom[10'h40] = mkw(4'd0, 4'h0, 10'h009);
    rom[10'h41] = mkw(4'd10, 4'hF, 10'h000);
    rom[1]    = mkw(4'd5, 4'h0, 10'h000);
    do_reset();
    serve(0, 32'h0, got, tg, w, ix, wd);
    chk("R8 R9 subroutine ran and returned", wd, 32'h9);
    run(10);
    chk("R9 return lands after call", {22'b0, rom_addr}, 32'd2);
    chk("R9 no stack error", {31'b0, stack_err}, 32'd0);

    // R10: overflow with saturation
    clear_rom();
    rom[0]      = mkw(4'd9, 4'hF, 10'h010);
    rom[10'h10] = mkw(4'd9, 4'hF, 10'h020);
    rom[10'h20] = mkw(4'd9, 4'hF, 10'h030);
    rom[10'h30] = mkw(4'd9, 4'hF, 10'h040);
    rom[10'h40] = mkw(4'd9, 4'hF, 10'h050);
    rom[10'h50] = mkw(4'd10, 4'hF, 10'h000);
    do_reset();
    run(40);
    chk("R10 overflow sets error", {31'b0, stack_err}, 32'd1);
    chk("R10 saturated stack returns to 0x31", {22'b0, rom_addr}, 32'h31);

    // R8 not taken then R10 underflow
    clear_rom();
    rom[0] = mkw(4'd9, 4'hC, 10'h040);
    rom[1] = mkw(4'd10, 4'hF, 10'h000);
    do_reset();
    run(20);
    chk("R8 untaken call skips, R10 underflow advances", {22'b0, rom_addr}, 32'd2);
    chk("R10 underflow sets error", {31'b0, stack_err}, 32'd1);
    run(10);
    chk("R10 error is sticky", {31'b0, stack_err}, 32'd1);
    do_reset();
    @(negedge clk);
    chk("R12 reset clears error", {31'b0, stack_err}, 32'd0);

    // R12: reset during stalled transfer
    clear_rom();
    rom[0] = mkw(4'd0, 4'h0, 10'h07E);
    rom[1] = mkw(4'd5, 4'h0, 10'h003);
    do_reset();
    run(8);
    chk("R5 request pending while not ready", {31'b0, xfer_valid}, 32'd1);
    chk("R1 stalled at word 1", {22'b0, rom_addr}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 reset drops request", {31'b0, xfer_valid}, 32'd0);
    chk("R12 reset returns to address 0", {22'b0, rom_addr}, 32'd0);
    @(negedge clk);
    chk("R1 address held in fetch", {22'b0, rom_addr}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule